// File: doc/BRIEF.md
# Audio Serial Clock Fault Monitor

This block watches the bit clock and the frame sync of an audio serial port from a faster, free-running reference clock. Both serial clocks are treated as asynchronous: each passes through a synchronizer, and the block then works on edge pulses. Each frame is measured in two ways. The first is its length in reference cycles, which is held against a programmable window. The second is the number of bit-clock rising edges it holds, which must be one of the supported ratios. Each clock also runs a timer that declares a stall when the clock stops toggling.

Any one of these conditions raises a single clock fault. The record path gets a shutdown command in the same cycle as the event that is detected. The fault clears only once two frames in a row have closed cleanly with no stall. At that point a one-cycle pulse asks the volume logic to ramp back to its earlier level. Software sees a live fault flag and a sticky flag that clears on read. An active-low interrupt request follows the sticky flag whenever the mask input is low.

Top module: `aclk_fault_mon`

## Requirements
- R1: After reset, err_live_o, err_latched_o, shutdown_o and ramp_o are 0 and irq_n_o is 1.
- R2: A closed frame whose length, counted in reference cycles from one frame-sync rising edge to the next, is below fs_min_i or above fs_max_i raises the fault. Both limits are inclusive, so a length equal to either limit is good.
- R3: A closed frame that holds a number of bit-clock rising edges outside {32, 48, 64, 96, 128, 192, 256, 384, 512} raises the fault.
- R4: When either serial clock shows no toggle for stall_lim_i reference cycles, the fault is raised and held until that clock toggles again.
- R5: shutdown_o is high in the cycle a fault event is detected and for as long as err_live_o is high.
- R6: err_live_o falls only after two consecutive clean frames have closed with no stall. After a stall, or after reset, the first frame-sync rising edge only starts measurement and closes no frame.
- R7: ramp_o gives a single one-cycle pulse each time err_live_o falls, and stays low at all other times.
- R8: err_latched_o is set while the fault is live. A pulse on rd_clr_i clears it only if the fault is no longer live.
- R9: irq_n_o is low exactly when err_latched_o is 1 and irq_mask_i is 0, so a mask value of 1 keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| fsync_i | input | 1 | Serial frame sync (asynchronous) |
| fs_min_i | input | PER_W (16) | Shortest allowed frame, in reference cycles |
| fs_max_i | input | PER_W (16) | Longest allowed frame, in reference cycles |
| stall_lim_i | input | STALL_W (16) | Stall timeout, in reference cycles |
| irq_mask_i | input | 1 | 1 blocks the interrupt request |
| rd_clr_i | input | 1 | Read strobe that clears the sticky flag |
| err_live_o | output | 1 | Live clock fault |
| err_latched_o | output | 1 | Sticky clock fault |
| irq_n_o | output | 1 | Interrupt request, active low |
| shutdown_o | output | 1 | Fast shutdown command for the record path |
| ramp_o | output | 1 | Pulse that starts the volume ramp-back |

## Verification
The bench uses the default parameters: 16-bit period and stall counters, a two-stage synchronizer, and two clean frames required for recovery. Inside that range it can run 256-cycle frames and set the window to a single value, which exercises the inclusive limits exactly. Bit clocks of two, four and eight reference cycles let one window accept 32 and 64 bits per frame and reject 50, and let a fast 64-bit frame break only the rate check. A stall limit of 400 cycles lies above every half-frame used, so only a deliberate hold of both clocks trips it.

// File: rtl/aclk_mon_pkg.sv
package aclk_mon_pkg;

  // Supported bit-clock edges per frame.
  function automatic logic ratio_ok(input int unsigned n);
    case (n)
      32, 48, 64, 96, 128, 192, 256, 384, 512: ratio_ok = 1'b1;
      default:                                 ratio_ok = 1'b0;
    endcase
  endfunction

  // Inclusive window test on a measured frame length.
  function automatic logic in_window(input int unsigned p,
                                     input int unsigned lo,
                                     input int unsigned hi);
    in_window = (p >= lo) && (p <= hi);
  endfunction

endpackage

// File: rtl/aclk_edge_sync.sv
module aclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic tog
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign tog  = sh_q[STAGES-1] ^ sh_q[STAGES];
endmodule

// File: rtl/aclk_stall_timer.sv
module aclk_stall_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tog,
  input  logic [W-1:0] limit,
  output logic         stall
);
  localparam logic [W-1:0] TMAX = {W{1'b1}};
  logic [W-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tmr_q <= '0;
    else if (tog)           tmr_q <= '0;
    else if (tmr_q != TMAX) tmr_q <= tmr_q + 1'b1;
  end

  assign stall = (tmr_q >= limit);

  // Any toggle restarts the timer (R4).
  p_edge_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tog |=> (tmr_q == '0));
endmodule

// File: rtl/aclk_frame_meter.sv
module aclk_frame_meter
  import aclk_mon_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int BIT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_rise,
  input  logic             bclk_rise,
  input  logic             stall,
  input  logic [PER_W-1:0] fs_min,
  input  logic [PER_W-1:0] fs_max,
  output logic             frame_done,
  output logic             frame_good
);
  localparam logic [PER_W-1:0] PMAX = {PER_W{1'b1}};
  localparam logic [BIT_W-1:0] BMAX = {BIT_W{1'b1}};

  logic [PER_W-1:0] per_q;
  logic [BIT_W-1:0] bits_q;
  logic             armed_q;
  logic [PER_W-1:0] per_meas;
  logic [BIT_W-1:0] bits_meas;
  logic             rate_good, ratio_good;

  assign per_meas   = (per_q == PMAX) ? PMAX : per_q + 1'b1;
  assign bits_meas  = (bclk_rise && bits_q != BMAX) ? bits_q + 1'b1 : bits_q;
  assign rate_good  = in_window(32'(per_meas), 32'(fs_min), 32'(fs_max));
  assign ratio_good = ratio_ok(32'(bits_meas));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q      <= '0;
      bits_q     <= '0;
      armed_q    <= 1'b0;
      frame_done <= 1'b0;
      frame_good <= 1'b0;
    end else begin
      frame_done <= fs_rise & armed_q & ~stall;
      frame_good <= rate_good & ratio_good;
      if (fs_rise)    armed_q <= 1'b1;
      else if (stall) armed_q <= 1'b0;
      if (fs_rise) begin
        per_q  <= '0;
        bits_q <= '0;
      end else begin
        if (per_q != PMAX)                 per_q  <= per_q + 1'b1;
        if (bclk_rise && bits_q != BMAX)   bits_q <= bits_q + 1'b1;
      end
    end
  end

  // A frame closes only after an earlier edge started measurement (R6).
  p_close_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(armed_q));
endmodule

// File: rtl/aclk_fault_ctrl.sv
module aclk_fault_ctrl #(
  parameter int GOOD_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall_any,
  input  logic frame_done,
  input  logic frame_good,
  input  logic rd_clr,
  input  logic irq_mask,
  output logic live,
  output logic latched,
  output logic irq_n,
  output logic shutdown,
  output logic ramp
);
  localparam int GW = $clog2(GOOD_FRAMES + 1);
  localparam logic [GW-1:0] LAST = GW'(GOOD_FRAMES - 1);

  logic [GW-1:0] good_q;
  logic          set_now, good_evt, live_nxt, latched_nxt;

  assign set_now     = stall_any | (frame_done & ~frame_good);
  assign good_evt    = frame_done & frame_good & ~stall_any;
  assign live_nxt    = set_now ? 1'b1
                     : (live & good_evt & (good_q == LAST)) ? 1'b0 : live;
  assign latched_nxt = live | (latched & ~rd_clr);
  assign shutdown    = live | set_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q  <= '0;
      live    <= 1'b0;
      latched <= 1'b0;
      irq_n   <= 1'b1;
      ramp    <= 1'b0;
    end else begin
      if (set_now)                               good_q <= '0;
      else if (good_evt && good_q != GW'(GOOD_FRAMES)) good_q <= good_q + 1'b1;
      live    <= live_nxt;
      ramp    <= live & ~live_nxt;
      latched <= latched_nxt;
      irq_n   <= ~(latched_nxt & ~irq_mask);
    end
  end

  p_shut_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live) |-> $past(shutdown));
  p_clear_on_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(live) |-> $past(frame_done));
  p_ramp_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ramp |-> ($past(live) && !live));
  p_latch_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> latched);
  p_clear_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latched) |-> ($past(rd_clr) && !$past(live)));
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_mask) |-> irq_n);
endmodule

// File: rtl/aclk_fault_mon.sv
module aclk_fault_mon #(
  parameter int PER_W       = 16,
  parameter int BIT_W       = 10,
  parameter int STALL_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GOOD_FRAMES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bclk_i,
  input  logic               fsync_i,
  input  logic [PER_W-1:0]   fs_min_i,
  input  logic [PER_W-1:0]   fs_max_i,
  input  logic [STALL_W-1:0] stall_lim_i,
  input  logic               irq_mask_i,
  input  logic               rd_clr_i,
  output logic               err_live_o,
  output logic               err_latched_o,
  output logic               irq_n_o,
  output logic               shutdown_o,
  output logic               ramp_o
);
  localparam int NCLK = 2; // index 0: bit clock, index 1: frame sync

  logic [NCLK-1:0] clk_in, clk_rise, clk_tog, clk_stall;
  logic            frame_done, frame_good;

  assign clk_in = {fsync_i, bclk_i};

  for (genvar g = 0; g < NCLK; g++) begin : g_lane
    aclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(clk_in[g]),
      .rise(clk_rise[g]), .tog(clk_tog[g]));
    aclk_stall_timer #(.W(STALL_W)) u_stall (
      .clk(clk), .rst_n(rst_n), .tog(clk_tog[g]),
      .limit(stall_lim_i), .stall(clk_stall[g]));
  end

  aclk_frame_meter #(.PER_W(PER_W), .BIT_W(BIT_W)) u_meter (
    .clk(clk), .rst_n(rst_n),
    .fs_rise(clk_rise[1]), .bclk_rise(clk_rise[0]),
    .stall(|clk_stall), .fs_min(fs_min_i), .fs_max(fs_max_i),
    .frame_done(frame_done), .frame_good(frame_good));

  aclk_fault_ctrl #(.GOOD_FRAMES(GOOD_FRAMES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .stall_any(|clk_stall),
    .frame_done(frame_done), .frame_good(frame_good),
    .rd_clr(rd_clr_i), .irq_mask(irq_mask_i),
    .live(err_live_o), .latched(err_latched_o), .irq_n(irq_n_o),
    .shutdown(shutdown_o), .ramp(ramp_o));
endmodule

// File: tb/tb_aclk_fault_mon.sv
module tb_aclk_fault_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, fsync = 1'b0;
  logic [15:0] fs_min = 16'd200, fs_max = 16'd300, stall_lim = 16'd400;
  logic        irq_mask = 1'b1, rd_clr = 1'b0;
  logic        live, latched, irq_n, shut, ramp;

  int errors = 0, checks = 0, ramp_seen = 0;
  bit done = 0;

  typedef struct {
    string req;
    logic  live, lat, shut, irqn;
    int    ramps;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  aclk_fault_mon dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync),
    .fs_min_i(fs_min), .fs_max_i(fs_max), .stall_lim_i(stall_lim),
    .irq_mask_i(irq_mask), .rd_clr_i(rd_clr),
    .err_live_o(live), .err_latched_o(latched), .irq_n_o(irq_n),
    .shutdown_o(shut), .ramp_o(ramp));

  // Monitor: counts ramp pulses and compares against queued expectations.
  always @(negedge clk) begin
    if (ramp) ramp_seen++;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (live !== e.live || latched !== e.lat || shut !== e.shut ||
          irq_n !== e.irqn || ramp_seen != e.ramps) begin
        errors++;
        $display("FAIL %s: live/lat/shut/irq_n/ramps = %b%b%b%b/%0d expected %b%b%b%b/%0d",
                 e.req, live, latched, shut, irq_n, ramp_seen,
                 e.live, e.lat, e.shut, e.irqn, e.ramps);
      end
    end
  end

  task automatic expect_now(string req, logic l, logic la, logic s, logic i, int r);
    exp_t e;
    e.req = req; e.live = l; e.lat = la; e.shut = s; e.irqn = i; e.ramps = r;
    sb_q.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  // Each bit lasts 2*h reference cycles; frame sync is high for the first half.
  task automatic run(int nbits, int h, int nfr, bit upd = 0, int nmin = 0, int nmax = 0);
    for (int f = 0; f < nfr; f++) begin
      for (int i = 0; i < nbits; i++) begin
        fsync = (i < nbits / 2);
        bclk  = 1'b0;
        if (upd && f == 0 && i == 1) begin
          fs_min = 16'(nmin);
          fs_max = 16'(nmax);
        end
        repeat (h) @(negedge clk);
        bclk = 1'b1;
        repeat (h) @(negedge clk);
      end
    end
  endtask

  task automatic pulse_clear();
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R1 reset state", 0, 0, 0, 1, 0);

    run(64, 2, 4);
    expect_now("R2 in-window 64-bit frames", 0, 0, 0, 1, 0);

    run(64, 1, 3);
    expect_now("R2 short frame, R9 masked", 1, 1, 1, 1, 0);

    irq_mask = 1'b0;
    @(negedge clk);
    expect_now("R9 unmasked irq", 1, 1, 1, 0, 0);

    pulse_clear();
    expect_now("R8 read while live keeps flag", 1, 1, 1, 0, 0);

    run(64, 2, 2);
    expect_now("R6 one clean frame not enough", 1, 1, 1, 0, 0);
    run(64, 2, 1);
    expect_now("R6 R7 recovery after two frames", 0, 1, 0, 0, 1);

    pulse_clear();
    expect_now("R8 R9 read clears after recovery", 0, 0, 0, 1, 1);

    run(50, 2, 3);
    expect_now("R3 50 bits per frame rejected", 1, 1, 1, 0, 1);
    run(32, 4, 3);
    expect_now("R3 32 bits per frame accepted", 0, 1, 0, 0, 2);
    pulse_clear();

    run(64, 2, 4, 1, 256, 256);
    expect_now("R2 length equal to both limits", 0, 0, 0, 1, 2);
    run(64, 2, 3, 1, 257, 300);
    expect_now("R2 length one below min", 1, 1, 1, 0, 2);
    run(64, 2, 4, 1, 200, 300);
    expect_now("R2 R7 window restored", 0, 1, 0, 0, 3);
    pulse_clear();

    repeat (450) @(negedge clk);
    expect_now("R4 R5 both clocks held", 1, 1, 1, 0, 3);
    run(64, 2, 2);
    expect_now("R6 first edge after stall only arms", 1, 1, 1, 0, 3);
    run(64, 2, 1);
    expect_now("R4 R6 recovery after stall", 0, 1, 0, 0, 4);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule